// File: doc/BRIEF.md
# Overwriting Result Buffer with Framed Serial Readout

This block stores converter results until a host reads them over a chip-select-framed serial link. A producer stream delivers 12-bit result words. Each word holds a 10-bit conversion value in bits 11:2 and two sub-bits in bits 1:0. A second stream carries temperature words with the same layout. Up to 16 converter results sit in a ring store. A single dedicated slot holds the most recent temperature word. When the ring is full, each new result pushes out the oldest one, so the producer is never stalled.

The host pulls chip select low and then clocks the serial line. Each frame returns one stored item as a 16-bit word, most significant bit first: four zero bits, then the 12 stored bits. A pending temperature word goes out before any converter result. When nothing is stored, the frame returns zeros. An item leaves the store only after all 16 bits of its word have been clocked out. Chip-select and serial-clock inputs are asynchronous to `clk`. They are resynchronised and edge-detected inside the block.

Both producer streams use valid/ready. Ready is high whenever reset is low, so a write completes in every cycle in which valid is high. There is no back-pressure. When the ring is full, the overwrite policy absorbs the extra results.

Top module: `rbuf_top`

## Requirements
- R1: While and after a synchronous reset, `fill_count` is 0, `empty` is 1, `sdo` is 0 and no temperature word is pending.
- R2: Across frames, converter results come out in the order they were written, oldest first.
- R3: A frame word is 16 bits. Bits 15:12 are zero, bits 11:2 are the result and bits 1:0 are the sub-bits, sent MSB first. Bit 15 is presented after chip select falls, and each later bit is presented after a falling edge of the serial clock.
- R4: A result written while 16 are stored replaces the oldest one, and `fill_count` stays 16. `cnv_ready` and `tmp_ready` are high whenever reset is low.
- R5: A frame started while nothing is stored returns 16 zero bits and leaves `fill_count` at 0.
- R6: While chip select is high, `sdo` is 0.
- R7: A frame ended by chip select rising before the 16th falling serial-clock edge removes nothing. The same item is returned by the next full frame.
- R8: A pending temperature word is sent before any converter result. Once it has been fully read, it is no longer pending.
- R9: A second temperature write replaces the first one. The next frame returns the newer value.
- R10: When a write and a completed read hit the full ring together, `fill_count` ends at 16. The ring then holds the 16 most recent results in order.
- R11: `fill_count` increases by one per write while below 16, decreases by one per completed result frame, and `empty` is high exactly when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cnv_valid | input | 1 | Converter result present |
| cnv_ready | output | 1 | Result accepted (high outside reset) |
| cnv_data | input | 12 | Result in bits 11:2, sub-bits in 1:0 |
| tmp_valid | input | 1 | Temperature word present |
| tmp_ready | output | 1 | Temperature word accepted (high outside reset) |
| tmp_data | input | 12 | Temperature word, same layout as results |
| cs_n | input | 1 | Frame select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdo | output | 1 | Serial data out |
| fill_count | output | 5 | Number of stored converter results |
| empty | output | 1 | No converter result stored |

## Verification
The assertions assume that `cs_n` and `sclk` change slowly compared with `clk`. Each level must be held for several `clk` cycles so the resynchroniser sees every edge. They also assume that `cs_n` sits high through reset. The bench holds every serial-clock phase and chip-select setup for six `clk` cycles, and it keeps chip select high during reset. It drives the producer streams only on falling `clk` edges, so each valid cycle is exactly one write. The bench models the ring as a queue trimmed to the newest 16 entries. Because of that, the burst of writes around the final serial edge in the concurrent case has a unique expected outcome, whichever cycle the removal lands in.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RING = 2'd1,
    SRC_TEMP = 2'd2
  } src_e;
endpackage

// File: rtl/rbuf_sync.sv
module rbuf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rbuf_ring.sv
module rbuf_ring #(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          take;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign take  = pop && !empty;
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      // on a full ring a write drops the oldest; a removal in the same
      // cycle drops that same slot, so the read side moves once either way
      if ((wr_en && full) || take) rd_ptr <= bump(rd_ptr);
      if (wr_en && !full && !take)      count <= count + 1'b1;
      else if (!wr_en && take)          count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rbuf_temp.sv
module rbuf_temp #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          snap,
  input  logic          clr,
  output logic          valid,
  output logic [DW-1:0] data
);
  logic fresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      fresh <= 1'b0;
      data  <= '0;
    end else if (wr_en) begin
      data  <= wr_data;
      valid <= 1'b1;
      fresh <= 1'b1;
    end else begin
      if (snap) fresh <= 1'b0;
      // a value written after the frame captured the slot survives the read
      if (clr && !fresh) valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rbuf_shifter.sv
module rbuf_shifter #(
  parameter int WORD_W = 16,
  localparam int NW    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              bit_adv,
  input  logic [WORD_W-1:0] load_word,
  output logic              sdo,
  output logic              done
);
  localparam logic [NW-1:0] LAST_BIT = NW'(WORD_W - 1);

  logic [WORD_W-1:0] sh;
  logic [NW-1:0]     nfall;
  logic              in_frame, armed;

  assign done = in_frame && armed && bit_adv && (nfall == LAST_BIT);
  assign sdo  = in_frame && sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      nfall    <= '0;
      in_frame <= 1'b0;
      armed    <= 1'b0;
    end else if (frame_start) begin
      sh       <= load_word;
      nfall    <= '0;
      in_frame <= 1'b1;
      armed    <= 1'b1;
    end else if (frame_end) begin
      in_frame <= 1'b0;
      armed    <= 1'b0;
    end else if (in_frame && bit_adv) begin
      sh <= {sh[WORD_W-2:0], 1'b0};
      if (armed) begin
        nfall <= nfall + 1'b1;
        if (nfall == LAST_BIT) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rbuf_top.sv
module rbuf_top #(
  parameter int DEPTH    = 16,
  parameter int RES_W    = 10,
  parameter int SUB_W    = 2,
  parameter int WORD_W   = 16,
  parameter int SYNC_STG = 2,
  localparam int DW      = RES_W + SUB_W,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnv_valid,
  output logic          cnv_ready,
  input  logic [DW-1:0] cnv_data,
  input  logic          tmp_valid,
  output logic          tmp_ready,
  input  logic [DW-1:0] tmp_data,
  input  logic          cs_n,
  input  logic          sclk,
  output logic          sdo,
  output logic [CW-1:0] fill_count,
  output logic          empty
);
  import rbuf_pkg::*;

  localparam int PAD_W = WORD_W - DW;

  logic          cs_s, cs_d, sclk_s, sclk_d;
  logic          cs_fall, cs_rise, sclk_fall;
  logic          ring_wr, tmp_wr, ring_pop, tmp_clr, tmp_snap, word_done;
  logic          ring_full, tmp_pend;
  logic [DW-1:0] ring_head, tmp_word, pick;
  src_e          src_sel, src_q;

  assign cnv_ready = !rst;
  assign tmp_ready = !rst;
  assign ring_wr   = cnv_valid && cnv_ready;
  assign tmp_wr    = tmp_valid && tmp_ready;

  rbuf_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .d(cs_n), .q(cs_s)
  );
  rbuf_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst(rst), .d(sclk), .q(sclk_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_fall   = cs_d && !cs_s;
  assign cs_rise   = !cs_d && cs_s;
  assign sclk_fall = sclk_d && !sclk_s && !cs_s;

  always_comb begin
    if (tmp_pend) begin
      src_sel = SRC_TEMP;
      pick    = tmp_word;
    end else if (!empty) begin
      src_sel = SRC_RING;
      pick    = ring_head;
    end else begin
      src_sel = SRC_NONE;
      pick    = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          src_q <= SRC_NONE;
    else if (cs_fall) src_q <= src_sel;
  end

  assign tmp_snap = cs_fall && (src_sel == SRC_TEMP);
  assign ring_pop = word_done && (src_q == SRC_RING);
  assign tmp_clr  = word_done && (src_q == SRC_TEMP);

  rbuf_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk(clk), .rst(rst), .wr_en(ring_wr), .wr_data(cnv_data),
    .pop(ring_pop), .head(ring_head), .count(fill_count),
    .empty(empty), .full(ring_full)
  );

  rbuf_temp #(.DW(DW)) u_temp (
    .clk(clk), .rst(rst), .wr_en(tmp_wr), .wr_data(tmp_data),
    .snap(tmp_snap), .clr(tmp_clr), .valid(tmp_pend), .data(tmp_word)
  );

  rbuf_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .frame_start(cs_fall), .frame_end(cs_rise),
    .bit_adv(sclk_fall), .load_word({{PAD_W{1'b0}}, pick}),
    .sdo(sdo), .done(word_done)
  );
endmodule

// File: rtl/rbuf_chk.sv
module rbuf_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cnv_valid,
  input logic          cs_n,
  input logic          sdo,
  input logic [CW-1:0] fill_count,
  input logic          empty
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnv_valid && fill_count == FULL_CNT) |=> (fill_count == FULL_CNT));

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_count <= FULL_CNT);

  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_count == $past(fill_count)) ||
    (fill_count == $past(fill_count) + 1'b1) ||
    (fill_count + 1'b1 == $past(fill_count)));

  // R11
  wr_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    cnv_valid |=> !empty);

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo);
endmodule

bind rbuf_top rbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cnv_valid(cnv_valid), .cs_n(cs_n),
  .sdo(sdo), .fill_count(fill_count), .empty(empty)
);

// File: tb/sim_rbuf_top.sv
module sim_rbuf_top;
  localparam int PH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnv_valid = 1'b0, tmp_valid = 1'b0;
  logic [11:0] cnv_data = '0, tmp_data = '0;
  logic        cnv_ready, tmp_ready;
  logic        cs_n = 1'b1, sclk = 1'b0;
  logic        sdo, empty;
  logic [4:0]  fill_count;

  int n_chk = 0, n_fail = 0;
  logic [11:0] exp_q[$];
  bit          tv = 1'b0;
  logic [11:0] td = '0;

  always #4 clk = ~clk;

  rbuf_top u0 (
    .clk(clk), .rst(rst), .cnv_valid(cnv_valid), .cnv_ready(cnv_ready),
    .cnv_data(cnv_data), .tmp_valid(tmp_valid), .tmp_ready(tmp_ready),
    .tmp_data(tmp_data), .cs_n(cs_n), .sclk(sclk), .sdo(sdo),
    .fill_count(fill_count), .empty(empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_result(input logic [11:0] d);
    @(negedge clk); cnv_valid = 1'b1; cnv_data = d;
    @(negedge clk); cnv_valid = 1'b0;
    exp_q.push_back(d);
    if (exp_q.size() > 16) void'(exp_q.pop_front());
  endtask

  task automatic push_temp(input logic [11:0] d);
    @(negedge clk); tmp_valid = 1'b1; tmp_data = d;
    @(negedge clk); tmp_valid = 1'b0;
    tv = 1'b1; td = d;
  endtask

  task automatic run_frame(input int nbits, output logic [15:0] w);
    w = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (PH) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      repeat (PH) @(negedge clk);
      w[15-i] = sdo;
      sclk = 1'b0;
      repeat (PH) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (PH) @(negedge clk);
  endtask

  // monitor side: one full frame compared with the scoreboard head
  task automatic read_check(input string req);
    logic [15:0] got, exp;
    if (tv) begin
      exp = {4'b0, td}; tv = 1'b0;
    end else if (exp_q.size() > 0) begin
      exp = {4'b0, exp_q.pop_front()};
    end else begin
      exp = '0;
    end
    run_frame(16, got);
    check(got == exp, req, got, exp);
  endtask

  task automatic frame_burst(input logic [11:0] base, output logic [15:0] w);
    w = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (PH) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b1;
      if (i < 15) begin
        repeat (PH) @(negedge clk);
        w[15-i] = sdo;
        sclk = 1'b0;
        repeat (PH) @(negedge clk);
      end else begin
        repeat (PH - 2) @(negedge clk);
        w[0] = sdo;
        cnv_valid = 1'b1; cnv_data = base;
        @(negedge clk); cnv_data = base + 12'd1;
        @(negedge clk); cnv_data = base + 12'd2; sclk = 1'b0;
        for (int k = 3; k < 8; k++) begin
          @(negedge clk); cnv_data = base + 12'(k);
        end
        @(negedge clk); cnv_valid = 1'b0;
      end
    end
    repeat (PH) @(negedge clk);
    cs_n = 1'b1;
    repeat (PH) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    repeat (5) @(negedge clk);
    // R1 state during reset
    check(fill_count == 0 && empty && !sdo, "R1", fill_count, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(fill_count == 0 && empty && !sdo, "R1", fill_count, 0);
    check(cnv_ready && tmp_ready, "R4 ready", cnv_ready, 1);

    // R5 empty read
    read_check("R5 empty frame");
    check(fill_count == 0, "R5 count", fill_count, 0);

    // R2 R3 ordering and format
    push_result(12'hABC); push_result(12'h001); push_result(12'h800);
    check(fill_count == 3 && !empty, "R11 count up", fill_count, 3);
    read_check("R3 word"); read_check("R2 order"); read_check("R2 order");
    check(fill_count == 0 && empty, "R11 count down", fill_count, 0);

    // R6 idle output with data stored
    push_result(12'hFFF);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!sdo, "R6 idle", sdo, 0);
    end

    // R7 aborted frame keeps the item
    run_frame(6, w);
    check(fill_count == 1, "R7 kept", fill_count, 1);
    read_check("R7 reread");

    // R4 overwrite on full
    for (int k = 1; k <= 20; k++) push_result(12'(k * 37));
    check(fill_count == 16, "R4 full", fill_count, 16);
    check(cnv_ready, "R4 ready full", cnv_ready, 1);
    for (int k = 0; k < 16; k++) read_check("R4 oldest dropped");
    check(empty, "R11 empty", empty, 1);

    // R8 temperature first, read once
    push_result(12'h123); push_result(12'h456); push_temp(12'h7A5);
    read_check("R8 temp first");
    read_check("R8 then results"); read_check("R8 then results");
    read_check("R8 temp consumed");

    // R9 temperature overwrite
    push_temp(12'h111); push_temp(12'h222);
    read_check("R9 newest temp");
    read_check("R9 consumed");

    // R10 write burst across a completed read on a full ring
    for (int k = 0; k < 16; k++) push_result(12'(12'h300 + k));
    frame_burst(12'h500, w);
    check(w == {4'b0, exp_q[0]}, "R10 sent word", w, {4'b0, exp_q[0]});
    void'(exp_q.pop_front());
    for (int k = 0; k < 8; k++) begin
      exp_q.push_back(12'(12'h500 + k));
      if (exp_q.size() > 16) void'(exp_q.pop_front());
    end
    check(fill_count == 16, "R10 count", fill_count, 16);
    for (int k = 0; k < 16; k++) read_check("R10 contents");
    check(fill_count == 0, "R10 drained", fill_count, 0);

    finish_run();
  end
endmodule